// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a small register of `WIDTH` flip-flops (four by default) that updates on the rising clock edge. A two-bit operation select picks one of four actions for each edge: wipe to zero, move the contents one place toward the high end, move them one place toward the low end, or capture a whole word from the parallel input. Each shift direction has its own serial input bit, which fills the vacated end.

The contents leave the block on a three-state bus output. The bus drives only while the output enable is high, so several of these registers can share one set of wires. A plain, always-driven copy of the contents sits beside the bus for local use.

The block has no reset pin. After power-up its contents are unknown until the first clear or load edge, so users start with one clear edge.

Top module: `usr_shift_reg`

## Requirements
- R1: With `op_sel` = 2'b11, a rising edge copies `par_in` into the register, and `word` shows that value after the edge.
- R2: During a parallel load, `ser_hi_in` and `ser_lo_in` have no effect on the value captured.
- R3: With `op_sel` = 2'b01, an edge moves bit i into bit i+1 for every i. `ser_lo_in` enters bit 0 and the old top bit is lost.
- R4: With `op_sel` = 2'b10, an edge moves bit i+1 into bit i for every i. `ser_hi_in` enters bit WIDTH-1 and the old bit 0 is lost.
- R5: With `op_sel` = 2'b00, an edge sets every bit to zero, including when the register held a nonzero value. This mode does not hold the contents.
- R6: While `bus_en` is high, `bus_q` drives the same value as `word`.
- R7: While `bus_en` is low, no bit of `bus_q` is driven, so another source on the same wires sets their value.
- R8: The register keeps updating on every edge while `bus_en` is low. Raising `bus_en` afterwards shows the updated contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| op_sel | input | 2 | Operation: 00 clear, 01 move up, 10 move down, 11 load |
| par_in | input | WIDTH | Parallel load word |
| ser_lo_in | input | 1 | Serial bit entering bit 0 on a move up |
| ser_hi_in | input | 1 | Serial bit entering the top bit on a move down |
| bus_en | input | 1 | High: drive `bus_q`; low: release it |
| bus_q | output | WIDTH | Three-state copy of the register |
| word | output | WIDTH | Always-driven copy of the register |

## Verification
The bench builds the block with the default `WIDTH` of 4. At that width all sixteen load words can be applied, and a single marked bit can be walked off either end within a handful of edges. The bench also drives the shared bus wires itself whenever the enable is low. A released bus then reads the bench's own pattern, which shows directly that the block has let go of the wires.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'b00,
    OP_UP    = 2'b01,
    OP_DOWN  = 2'b10,
    OP_LOAD  = 2'b11
  } op_t;
endpackage

// File: rtl/usr_op_decode.sv
module usr_op_decode
  import usr_pkg::*;
(
  input  logic [1:0] op_sel,
  output logic       do_clear,
  output logic       do_up,
  output logic       do_down,
  output logic       do_load
);
  always_comb begin
    do_clear = 1'b0;
    do_up    = 1'b0;
    do_down  = 1'b0;
    do_load  = 1'b0;
    unique case (op_t'(op_sel))
      OP_CLEAR: do_clear = 1'b1;
      OP_UP:    do_up    = 1'b1;
      OP_DOWN:  do_down  = 1'b1;
      OP_LOAD:  do_load  = 1'b1;
      default:  do_clear = 1'b1;
    endcase
  end
endmodule

// File: rtl/usr_stage_bank.sv
module usr_stage_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             do_clear,
  input  logic             do_up,
  input  logic             do_down,
  input  logic             do_load,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  output logic [WIDTH-1:0] stages
);
  localparam int TOP = WIDTH - 1;

  // Whole-word views of the two moves; each stage picks its own bit below.
  function automatic logic [WIDTH-1:0] move_up(input logic [WIDTH-1:0] q, input logic fill);
    move_up = {q[TOP-1:0], fill};
  endfunction

  function automatic logic [WIDTH-1:0] move_down(input logic [WIDTH-1:0] q, input logic fill);
    move_down = {fill, q[TOP:1]};
  endfunction

  logic [WIDTH-1:0] up_vec;
  logic [WIDTH-1:0] down_vec;

  assign up_vec   = move_up(stages, ser_lo_in);
  assign down_vec = move_down(stages, ser_hi_in);

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic nxt;
    always_comb begin
      nxt = 1'b0;
      if (do_load)      nxt = par_in[i];
      else if (do_up)   nxt = up_vec[i];
      else if (do_down) nxt = down_vec[i];
      else if (do_clear) nxt = 1'b0;
    end
    always_ff @(posedge clk) stages[i] <= nxt;
  end
endmodule

// File: rtl/usr_bus_driver.sv
module usr_bus_driver #(
  parameter int WIDTH = 4
) (
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output wire  [WIDTH-1:0] pad
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pad[i] = en ? d[i] : 1'bz;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  input  logic             bus_en,
  output wire  [WIDTH-1:0] bus_q,
  output logic [WIDTH-1:0] word
);
  logic do_clear, do_up, do_down, do_load;

  usr_op_decode u_dec (
    .op_sel   (op_sel),
    .do_clear (do_clear),
    .do_up    (do_up),
    .do_down  (do_down),
    .do_load  (do_load)
  );

  usr_stage_bank #(.WIDTH(WIDTH)) u_bank (
    .clk       (clk),
    .do_clear  (do_clear),
    .do_up     (do_up),
    .do_down   (do_down),
    .do_load   (do_load),
    .par_in    (par_in),
    .ser_lo_in (ser_lo_in),
    .ser_hi_in (ser_hi_in),
    .stages    (word)
  );

  usr_bus_driver #(.WIDTH(WIDTH)) u_drv (
    .en  (bus_en),
    .d   (word),
    .pad (bus_q)
  );
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] par_in,
  input logic             ser_lo_in,
  input logic             ser_hi_in,
  input logic             bus_en,
  input logic [WIDTH-1:0] bus_q,
  input logic [WIDTH-1:0] word
);
  // Contents are defined only after the first clear or load edge.
  logic primed = 1'b0;
  always_ff @(posedge clk)
    if (op_sel == 2'b00 || op_sel == 2'b11) primed <= 1'b1;

  assert_load_R1: assert property (@(posedge clk) disable iff (!primed)
    op_sel == 2'b11 |=> word == $past(par_in));

  assert_up_R3: assert property (@(posedge clk) disable iff (!primed)
    op_sel == 2'b01 |=> word == {$past(word[WIDTH-2:0]), $past(ser_lo_in)});

  assert_down_R4: assert property (@(posedge clk) disable iff (!primed)
    op_sel == 2'b10 |=> word == {$past(ser_hi_in), $past(word[WIDTH-1:1])});

  assert_clear_R5: assert property (@(posedge clk) disable iff (!primed)
    op_sel == 2'b00 |=> word == '0);

  assert_bus_R6: assert property (@(posedge clk) disable iff (!primed)
    bus_en |-> bus_q === word);
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .op_sel    (op_sel),
  .par_in    (par_in),
  .ser_lo_in (ser_lo_in),
  .ser_hi_in (ser_hi_in),
  .bus_en    (bus_en),
  .bus_q     (bus_q),
  .word      (word)
);

// File: tb/test_usr_shift_reg.sv
`timescale 1ns/1ps
module test_usr_shift_reg;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] par_in = '0;
  logic         ser_lo_in = 1'b0;
  logic         ser_hi_in = 1'b0;
  logic         bus_en = 1'b1;
  logic         tb_drive = 1'b0;
  logic [W-1:0] tb_val = '0;
  wire  [W-1:0] bus;
  logic [W-1:0] word;
  logic [W-1:0] model;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign bus = tb_drive ? tb_val : 'z;

  usr_shift_reg #(.WIDTH(W)) i_usr_shift_reg (
    .clk(clk), .op_sel(op_sel), .par_in(par_in), .ser_lo_in(ser_lo_in),
    .ser_hi_in(ser_hi_in), .bus_en(bus_en), .bus_q(bus), .word(word)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Apply inputs away from the edge, take one edge, sample 1 ns later.
  task automatic step(input logic [1:0] op, input logic [W-1:0] p, input logic lo, input logic hi);
    @(negedge clk);
    op_sel = op; par_in = p; ser_lo_in = lo; ser_hi_in = hi;
    @(posedge clk);
    #1;
    case (op)
      2'b00: model = '0;
      2'b01: model = (model << 1) | W'(lo);
      2'b10: model = (model >> 1) | (W'(hi) << (W-1));
      default: model = p;
    endcase
  endtask

  task automatic t_init_clear;
    model = 'x;
    step(2'b00, 4'hF, 1'b1, 1'b1);
    check("R5 init clear", word, 4'h0);
    check("R6 bus after clear", bus, 4'h0);
  endtask

  task automatic t_load_all;
    for (int v = 0; v < 16; v++) begin
      step(2'b11, W'(v), v[0], v[1]);
      check("R1 load", word, W'(v));
    end
  endtask

  task automatic t_load_ignores_serial;
    step(2'b11, 4'b0110, 1'b1, 1'b1);
    check("R2 load serial high", word, 4'b0110);
    step(2'b11, 4'b1001, 1'b0, 1'b0);
    check("R2 load serial low", word, 4'b1001);
  endtask

  task automatic t_move_up;
    step(2'b11, 4'b0001, 1'b0, 1'b0);
    step(2'b01, 4'hF, 1'b0, 1'b1);
    check("R3 up 1", word, 4'b0010);
    step(2'b01, 4'hF, 1'b1, 1'b0);
    check("R3 up 2", word, 4'b0101);
    step(2'b01, 4'h0, 1'b0, 1'b1);
    check("R3 up 3", word, 4'b1010);
    step(2'b01, 4'h0, 1'b0, 1'b0);
    check("R3 up top lost", word, 4'b0100);
    check("R3 model", word, model);
  endtask

  task automatic t_move_down;
    step(2'b11, 4'b1000, 1'b0, 1'b0);
    step(2'b10, 4'hF, 1'b1, 1'b0);
    check("R4 down 1", word, 4'b0100);
    step(2'b10, 4'hF, 1'b0, 1'b1);
    check("R4 down 2", word, 4'b1010);
    step(2'b10, 4'h0, 1'b1, 1'b0);
    check("R4 down 3", word, 4'b0101);
    step(2'b10, 4'h0, 1'b1, 1'b0);
    check("R4 down bit0 lost", word, 4'b0010);
    check("R4 model", word, model);
  endtask

  task automatic t_clear_not_hold;
    step(2'b11, 4'b1111, 1'b0, 1'b0);
    step(2'b00, 4'b1111, 1'b1, 1'b1);
    check("R5 clear from ones", word, 4'h0);
    step(2'b11, 4'b1010, 1'b0, 1'b0);
    step(2'b00, 4'b0101, 1'b0, 1'b0);
    check("R5 clear from 1010", bus, 4'h0);
  endtask

  task automatic t_bus_release;
    step(2'b11, 4'b1100, 1'b0, 1'b0);
    check("R6 bus drives", bus, 4'b1100);
    @(negedge clk);
    bus_en = 1'b0; tb_drive = 1'b1; tb_val = 4'b0011;
    #1;
    check("R7 released 0011", bus, 4'b0011);
    tb_val = 4'b1010;
    #1;
    check("R7 released 1010", bus, 4'b1010);
    check("R7 word kept", word, 4'b1100);
  endtask

  task automatic t_update_while_released;
    // bus_en still low, bench still driving the wires
    step(2'b01, 4'h0, 1'b1, 1'b0);
    check("R8 update hidden", word, 4'b1001);
    step(2'b10, 4'h0, 1'b0, 1'b1);
    check("R8 update hidden 2", word, 4'b1100);
    check("R8 bus stays released", bus, 4'b1010);
    @(negedge clk);
    tb_drive = 1'b0; bus_en = 1'b1;
    #1;
    check("R8 bus shows updated", bus, 4'b1100);
  endtask

  initial begin
    t_init_clear();
    t_load_all();
    t_load_ignores_serial();
    t_move_up();
    t_move_down();
    t_clear_not_hold();
    t_bus_release();
    t_update_while_released();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule